// File: doc/BRIEF.md
# Prioritized Interrupt and Exception Vectoring Controller

This block sits beside a CPU front end and chooses the next event the core must take. The events are a reset request, two non-maskable interrupts (one from a pin and one from a watchdog), two synchronous exceptions (an illegal-opcode flag and a software trap that carries a 5-bit number), and a vector of maskable interrupt requests. Each maskable source has its own mask bit and a programmable priority. The block turns the winning event into a 16-bit exception code, a 32-bit handler address and a flag. The flag tells the core whether to save the address of the next instruction as the return address.

The chosen event is latched into output registers and offered with a valid signal until the core accepts it. Maskable interrupts nest. When the core accepts a maskable event, the block pushes its priority onto a small in-service stack. A return pulse pops that level off the stack. A new maskable request is eligible only when its priority is strictly higher than the level on top of the stack. Pipeline control, context saving and pin edge filtering belong to other blocks.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A reset request yields code 0000H, handler 00000000H and a save-next-PC flag of 0. It wins over every other pending event.
- R2: The pin non-maskable request yields code 0010H and handler 00000010H. The watchdog request yields code 0020H and handler 00000020H. The pin request wins over the watchdog request. Neither is affected by the global enable or by any mask bit.
- R3: A trap whose number has bit 4 clear and low nibble n yields code 0040H+n and handler 00000040H. A trap with bit 4 set yields code 0050H+n and handler 00000050H.
- R4: An illegal opcode yields code 0060H and handler 00000060H. It wins over a trap and loses to both non-maskable requests.
- R5: Maskable source k yields code 0080H+16·k and handler 00000080H+16·k. A source is taken only when the global enable is 1 and its mask bit is 0. A mask bit of 1 blocks the source.
- R6: Each maskable source has a 3-bit priority field at bits [3k+2:3k] of the priority bus, where a lower value means higher priority. Among eligible sources the lowest value wins. If two sources share that value, the lower index wins.
- R7: The current level output is 8 when the stack is empty, and otherwise equals the priority on top of the stack. A maskable request is eligible only if its priority value is strictly less than the current level.
- R8: The valid output and the registered outputs change on the clock edge that samples the request. Valid then stays high, with the outputs held, until the core accepts. Valid is low after the accepting edge. Accepting a maskable event pushes its priority onto the stack, so the current level changes on that same edge. Accepting a non-maskable event or an exception leaves the stack unchanged.
- R9: A return pulse pops the top stack entry. A return pulse on an empty stack has no effect. If a return pulse and an accept of a maskable event arrive in the same cycle, the top entry is replaced by the accepted priority.
- R10: While valid is high, the offered event is replaced only by an event of a higher class, or by a maskable event with a strictly lower priority value. An equal or lower event leaves the outputs unchanged.
- R11: The save-next-PC flag is 1 for every event class except reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| resetReq | input | 1 | Reset event request |
| nmiPin | input | 1 | Pin non-maskable request |
| nmiWdt | input | 1 | Watchdog non-maskable request |
| illegalOp | input | 1 | Illegal opcode flag from the decoder |
| trapReq | input | 1 | Software trap request |
| trapNum | input | 5 | Trap number |
| irqReq | input | NUM_IRQ | Maskable requests |
| irqMask | input | NUM_IRQ | Mask bits, 1 blocks |
| irqPrio | input | NUM_IRQ*PRIO_W | Priority fields, 3 bits per source |
| globalEn | input | 1 | Global enable for maskable requests |
| accept | input | 1 | Core accepts the offered event |
| retPulse | input | 1 | Return from handler |
| evtValid | output | 1 | An event is offered |
| excCode | output | 16 | Exception code |
| handlerAddr | output | 32 | Handler address |
| saveNextPc | output | 1 | Save the next PC as the return address |
| curLevel | output | PRIO_W+1 | Current in-service level, 8 when idle |

## Verification
Every result is due one clock edge after the stimulus that causes it. A request driven in one cycle shows up on valid, the code, the address and the flag after the next edge. An accept or return pulse changes valid and the current level on the edge that samples it. The bench drives inputs on the falling edge and samples at the following falling edge, so each check lands exactly one rising edge after its stimulus. Tests that must show nothing happened, such as a blocked source, an equal-priority request, or a return on an empty stack, look at the ports at that same point.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  // Lower value = higher precedence; the order is behaviour.
  typedef enum logic [2:0] {
    CLS_RESET    = 3'd0,
    CLS_NMI_PIN  = 3'd1,
    CLS_NMI_WDT  = 3'd2,
    CLS_ILLEGAL  = 3'd3,
    CLS_TRAP     = 3'd4,
    CLS_MASKABLE = 3'd5,
    CLS_NONE     = 3'd7
  } evtClass_e;

  typedef struct packed {
    logic load;  // capture the current candidate
    logic drop;  // offered event accepted, release it
  } dpStrobe_t;

  localparam logic [15:0] CODE_RESET   = 16'h0000;
  localparam logic [15:0] CODE_NMI_PIN = 16'h0010;
  localparam logic [15:0] CODE_NMI_WDT = 16'h0020;
  localparam logic [15:0] CODE_TRAP_LO = 16'h0040;
  localparam logic [15:0] CODE_TRAP_HI = 16'h0050;
  localparam logic [15:0] CODE_ILLEGAL = 16'h0060;
  localparam logic [15:0] CODE_IRQ_BASE = 16'h0080;

endpackage

// File: rtl/irqv_datapath.sv
module irqv_datapath
  import irqv_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      resetReq,
  input  logic                      nmiPin,
  input  logic                      nmiWdt,
  input  logic                      illegalOp,
  input  logic                      trapReq,
  input  logic [4:0]                trapNum,
  input  logic [NUM_IRQ-1:0]        irqReq,
  input  logic [NUM_IRQ-1:0]        irqMask,
  input  logic [NUM_IRQ*PRIO_W-1:0] irqPrio,
  input  logic                      globalEn,
  input  logic [PRIO_W:0]           curLevel,
  input  dpStrobe_t                 strb,
  output evtClass_e                 candClass,
  output logic [PRIO_W-1:0]         candPrio,
  output evtClass_e                 heldClass,
  output logic [PRIO_W-1:0]         heldPrio,
  output logic [15:0]               excCode,
  output logic [31:0]               handlerAddr,
  output logic                      saveNextPc
);

  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [PRIO_W-1:0] srcPrio [NUM_IRQ];
  logic [NUM_IRQ-1:0] eligible;

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_src
    assign srcPrio[k]  = irqPrio[k*PRIO_W +: PRIO_W];
    assign eligible[k] = irqReq[k] & ~irqMask[k] & globalEn &
                         ({1'b0, srcPrio[k]} < curLevel);
  end

  logic              bestHit;
  logic [IDX_W-1:0]  bestIdx;
  logic [PRIO_W-1:0] bestPrio;

  // Ascending scan with strict compare: ties keep the lower index.
  always_comb begin
    bestHit  = 1'b0;
    bestIdx  = '0;
    bestPrio = '0;
    for (int k = 0; k < NUM_IRQ; k++) begin
      if (eligible[k] && (!bestHit || srcPrio[k] < bestPrio)) begin
        bestHit  = 1'b1;
        bestIdx  = IDX_W'(k);
        bestPrio = srcPrio[k];
      end
    end
  end

  always_comb begin
    candPrio = '0;
    if (resetReq)       candClass = CLS_RESET;
    else if (nmiPin)    candClass = CLS_NMI_PIN;
    else if (nmiWdt)    candClass = CLS_NMI_WDT;
    else if (illegalOp) candClass = CLS_ILLEGAL;
    else if (trapReq)   candClass = CLS_TRAP;
    else if (bestHit) begin
      candClass = CLS_MASKABLE;
      candPrio  = bestPrio;
    end
    else                candClass = CLS_NONE;
  end

  logic [15:0] candCode;
  logic [31:0] candAddr;

  always_comb begin
    unique case (candClass)
      CLS_RESET:   begin candCode = CODE_RESET;   candAddr = 32'(CODE_RESET);   end
      CLS_NMI_PIN: begin candCode = CODE_NMI_PIN; candAddr = 32'(CODE_NMI_PIN); end
      CLS_NMI_WDT: begin candCode = CODE_NMI_WDT; candAddr = 32'(CODE_NMI_WDT); end
      CLS_ILLEGAL: begin candCode = CODE_ILLEGAL; candAddr = 32'(CODE_ILLEGAL); end
      CLS_TRAP: begin
        candCode = (trapNum[4] ? CODE_TRAP_HI : CODE_TRAP_LO) | {12'h000, trapNum[3:0]};
        candAddr = 32'(trapNum[4] ? CODE_TRAP_HI : CODE_TRAP_LO);
      end
      CLS_MASKABLE: begin
        candCode = CODE_IRQ_BASE + {(16 - IDX_W - 4)'(0), bestIdx, 4'h0};
        candAddr = 32'(candCode);
      end
      default: begin candCode = '0; candAddr = '0; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldClass   <= CLS_NONE;
      heldPrio    <= '0;
      excCode     <= '0;
      handlerAddr <= '0;
      saveNextPc  <= 1'b0;
    end else if (strb.drop) begin
      heldClass <= CLS_NONE;
    end else if (strb.load) begin
      heldClass   <= candClass;
      heldPrio    <= candPrio;
      excCode     <= candCode;
      handlerAddr <= candAddr;
      saveNextPc  <= (candClass != CLS_RESET);
    end
  end

  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    resetReq && !strb.drop |=> heldClass == CLS_RESET && excCode == 16'h0000) // R1
    else $error("reset request not taken");

  AST_NMI_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    nmiPin && !resetReq && !strb.drop && heldClass != CLS_RESET
      |=> heldClass == CLS_NMI_PIN) // R2
    else $error("pin NMI not taken");

  AST_CODE_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    heldClass == CLS_MASKABLE |-> excCode[3:0] == 4'h0 && {16'h0000, excCode} == handlerAddr) // R5
    else $error("maskable code and address disagree");

  AST_SAVE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    heldClass != CLS_NONE |-> saveNextPc == (heldClass != CLS_RESET)) // R11
    else $error("save-next-PC flag wrong");

endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
  import irqv_pkg::*;
#(
  parameter int PRIO_W = 3,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  evtClass_e         candClass,
  input  logic [PRIO_W-1:0] candPrio,
  input  evtClass_e         heldClass,
  input  logic [PRIO_W-1:0] heldPrio,
  input  logic              accept,
  input  logic              retPulse,
  output dpStrobe_t         strb,
  output logic              evtValid,
  output logic [PRIO_W:0]   curLevel
);

  localparam int DEPTH_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PRIO_W:0] LEVEL_IDLE = (PRIO_W+1)'(1 << PRIO_W);

  logic [PRIO_W-1:0] stackMem [DEPTH];
  logic [DEPTH_W:0]  depth;
  logic [DEPTH_W-1:0] wrIdx, topIdx;
  logic better, push, pop;

  assign wrIdx  = depth[DEPTH_W-1:0];
  assign topIdx = DEPTH_W'(depth - 1'b1);
  assign curLevel = (depth == '0) ? LEVEL_IDLE : {1'b0, stackMem[topIdx]};

  assign better = (candClass < heldClass) ||
                  (candClass == CLS_MASKABLE && heldClass == CLS_MASKABLE &&
                   candPrio < heldPrio);

  assign strb.drop = evtValid & accept;
  assign strb.load = !strb.drop && candClass != CLS_NONE && (!evtValid || better);

  assign push = strb.drop && heldClass == CLS_MASKABLE;
  assign pop  = retPulse && depth != '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          evtValid <= 1'b0;
    else if (strb.drop) evtValid <= 1'b0;
    else if (strb.load) evtValid <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depth <= '0;
      for (int i = 0; i < DEPTH; i++) stackMem[i] <= '0;
    end else if (push && pop) begin
      stackMem[topIdx] <= heldPrio;
    end else if (push) begin
      stackMem[wrIdx] <= heldPrio;
      depth <= depth + 1'b1;
    end else if (pop) begin
      depth <= depth - 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    push && !pop |-> depth < (DEPTH_W+1)'(DEPTH)) // R8
    else $error("in-service stack overflow");

  AST_NEST_STRICT: assert property (@(posedge clk) disable iff (!rstN)
    push |-> {1'b0, heldPrio} < curLevel) // R7
    else $error("nested level not strictly higher");

  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rstN)
    evtValid && !accept |=> evtValid) // R8
    else $error("offer withdrawn before accept");

  AST_EMPTY_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    retPulse && depth == '0 && !push |=> depth == '0) // R9
    else $error("return on empty stack changed depth");

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 3,
  parameter int DEPTH   = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      resetReq,
  input  logic                      nmiPin,
  input  logic                      nmiWdt,
  input  logic                      illegalOp,
  input  logic                      trapReq,
  input  logic [4:0]                trapNum,
  input  logic [NUM_IRQ-1:0]        irqReq,
  input  logic [NUM_IRQ-1:0]        irqMask,
  input  logic [NUM_IRQ*PRIO_W-1:0] irqPrio,
  input  logic                      globalEn,
  input  logic                      accept,
  input  logic                      retPulse,
  output logic                      evtValid,
  output logic [15:0]               excCode,
  output logic [31:0]               handlerAddr,
  output logic                      saveNextPc,
  output logic [PRIO_W:0]           curLevel
);

  dpStrobe_t         strb;
  evtClass_e         candClass, heldClass;
  logic [PRIO_W-1:0] candPrio, heldPrio;

  irqv_datapath #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_dp (
    .clk(clk), .rstN(rstN), .resetReq(resetReq), .nmiPin(nmiPin), .nmiWdt(nmiWdt),
    .illegalOp(illegalOp), .trapReq(trapReq), .trapNum(trapNum), .irqReq(irqReq),
    .irqMask(irqMask), .irqPrio(irqPrio), .globalEn(globalEn), .curLevel(curLevel),
    .strb(strb), .candClass(candClass), .candPrio(candPrio), .heldClass(heldClass),
    .heldPrio(heldPrio), .excCode(excCode), .handlerAddr(handlerAddr),
    .saveNextPc(saveNextPc)
  );

  irqv_ctrl #(.PRIO_W(PRIO_W), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .candClass(candClass), .candPrio(candPrio),
    .heldClass(heldClass), .heldPrio(heldPrio), .accept(accept), .retPulse(retPulse),
    .strb(strb), .evtValid(evtValid), .curLevel(curLevel)
  );

endmodule

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vector_ctrl_bench;

  localparam int NUM_IRQ = 8;
  localparam int PRIO_W  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic resetReq = 1'b0, nmiPin = 1'b0, nmiWdt = 1'b0, illegalOp = 1'b0, trapReq = 1'b0;
  logic [4:0] trapNum = '0;
  logic [NUM_IRQ-1:0] irqReq = '0, irqMask = '0;
  logic [NUM_IRQ*PRIO_W-1:0] irqPrio = '0;
  logic globalEn = 1'b0, accept = 1'b0, retPulse = 1'b0;
  logic evtValid, saveNextPc;
  logic [15:0] excCode;
  logic [31:0] handlerAddr;
  logic [PRIO_W:0] curLevel;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rstN(rstN), .resetReq(resetReq), .nmiPin(nmiPin), .nmiWdt(nmiWdt),
    .illegalOp(illegalOp), .trapReq(trapReq), .trapNum(trapNum), .irqReq(irqReq),
    .irqMask(irqMask), .irqPrio(irqPrio), .globalEn(globalEn), .accept(accept),
    .retPulse(retPulse), .evtValid(evtValid), .excCode(excCode),
    .handlerAddr(handlerAddr), .saveNextPc(saveNextPc), .curLevel(curLevel)
  );

  typedef struct packed {
    logic        rst, nmiP, wdt, ill, trap;
    logic [4:0]  tnum;
    logic [7:0]  req, mask;
    logic        gen;
    logic [23:0] prio;
    logic [15:0] code;
    logic [31:0] addr;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,1'b1,1'b1,1'b1,5'h03,8'hFF,8'h00,1'b1,24'h0,16'h0000,32'h00}, // R1
    '{1'b0,1'b1,1'b1,1'b1,1'b0,5'h00,8'h00,8'h00,1'b0,24'h0,16'h0010,32'h10}, // R2 R4
    '{1'b0,1'b0,1'b1,1'b0,1'b0,5'h00,8'hFF,8'hFF,1'b0,24'h0,16'h0020,32'h20}, // R2
    '{1'b0,1'b0,1'b0,1'b1,1'b1,5'h0A,8'h00,8'h00,1'b0,24'h0,16'h0060,32'h60}, // R4
    '{1'b0,1'b0,1'b0,1'b0,1'b1,5'h07,8'h00,8'h00,1'b0,24'h0,16'h0047,32'h40}, // R3
    '{1'b0,1'b0,1'b0,1'b0,1'b1,5'h1C,8'h00,8'h00,1'b0,24'h0,16'h005C,32'h50}, // R3
    '{1'b0,1'b0,1'b0,1'b0,1'b0,5'h00,8'h08,8'h00,1'b1,24'h0,16'h00B0,32'hB0}, // R5
    '{1'b0,1'b0,1'b0,1'b0,1'b0,5'h00,8'hA0,8'h00,1'b1,24'h218000,16'h00F0,32'hF0}, // R6
    '{1'b0,1'b0,1'b0,1'b0,1'b0,5'h00,8'h44,8'h00,1'b1,24'h0,16'h00A0,32'hA0}, // R6
    '{1'b0,1'b0,1'b0,1'b0,1'b0,5'h00,8'h03,8'h01,1'b1,24'h0,16'h0090,32'h90}  // R5
  };

  function automatic string vecTag(int i);
    case (i)
      0: return "R1";
      1: return "R2/R4";
      2: return "R2";
      3: return "R4";
      4, 5: return "R3";
      6, 9: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clearIn();
    resetReq = 0; nmiPin = 0; nmiWdt = 0; illegalOp = 0; trapReq = 0;
    trapNum = '0; irqReq = '0; irqMask = '0; globalEn = 0;
  endtask

  task automatic setPrio(int k, int v);
    irqPrio[k*PRIO_W +: PRIO_W] = PRIO_W'(v);
  endtask

  task automatic acceptNow();
    clearIn();
    accept = 1;
    tick();
    accept = 0;
  endtask

  task automatic returnNow();
    retPulse = 1;
    tick();
    retPulse = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    check("R8", "valid after reset", 64'(evtValid), 64'd0);
    check("R7", "idle level after reset", 64'(curLevel), 64'd8);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      resetReq = VECS[i].rst; nmiPin = VECS[i].nmiP; nmiWdt = VECS[i].wdt;
      illegalOp = VECS[i].ill; trapReq = VECS[i].trap; trapNum = VECS[i].tnum;
      irqReq = VECS[i].req; irqMask = VECS[i].mask; globalEn = VECS[i].gen;
      irqPrio = VECS[i].prio;
      tick();
      check(vecTag(i), "valid", 64'(evtValid), 64'd1);
      check(vecTag(i), "code", 64'(excCode), 64'(VECS[i].code));
      check(vecTag(i), "addr", 64'(handlerAddr), 64'(VECS[i].addr));
      check("R11", "save flag", 64'(saveNextPc), 64'(VECS[i].code != 16'h0000));
      acceptNow();
      check("R8", "valid after accept", 64'(evtValid), 64'd0);
      returnNow();
      check("R9", "level after return", 64'(curLevel), 64'd8);
    end
    irqPrio = '0;

    // R5: global enable low blocks maskable sources
    irqReq = 8'h01; globalEn = 0;
    tick(); tick();
    check("R5", "blocked by global enable", 64'(evtValid), 64'd0);
    clearIn();

    // R8: offer held until accept
    irqReq = 8'h01; globalEn = 1;
    tick();
    clearIn();
    tick(); tick();
    check("R8", "held valid", 64'(evtValid), 64'd1);
    check("R8", "held code", 64'(excCode), 64'h80);
    acceptNow();
    check("R8", "level after accept prio 0", 64'(curLevel), 64'd0);
    returnNow();
    check("R9", "level back to idle", 64'(curLevel), 64'd8);

    // R7 nesting
    setPrio(4, 3); setPrio(1, 3); setPrio(2, 2);
    irqReq = 8'h10; globalEn = 1;
    tick();
    check("R5", "k4 code", 64'(excCode), 64'hC0);
    acceptNow();
    check("R8", "level after k4 accept", 64'(curLevel), 64'd3);
    irqReq = 8'h02; globalEn = 1;
    tick();
    check("R7", "equal priority not taken", 64'(evtValid), 64'd0);
    irqReq = 8'h06;
    tick();
    check("R7", "higher priority preempts", 64'(excCode), 64'hA0);
    acceptNow();
    check("R8", "nested level", 64'(curLevel), 64'd2);
    returnNow();
    check("R9", "pop to outer level", 64'(curLevel), 64'd3);
    returnNow();
    check("R9", "pop to idle", 64'(curLevel), 64'd8);
    returnNow();
    check("R9", "return on empty ignored", 64'(curLevel), 64'd8);
    irqPrio = '0;

    // R10 replacement rules while valid
    setPrio(6, 5); setPrio(0, 5);
    irqReq = 8'h40; globalEn = 1;
    tick();
    check("R10", "first offer", 64'(excCode), 64'hE0);
    irqReq = 8'h41;
    tick();
    check("R10", "equal priority keeps offer", 64'(excCode), 64'hE0);
    nmiPin = 1;
    tick();
    check("R10", "higher class replaces", 64'(excCode), 64'h10);
    acceptNow();
    check("R8", "NMI accept leaves stack", 64'(curLevel), 64'd8);
    check("R8", "valid low after NMI accept", 64'(evtValid), 64'd0);
    irqPrio = '0;

    // R9 accept and return together
    setPrio(3, 4); setPrio(1, 1);
    irqReq = 8'h08; globalEn = 1;
    tick();
    acceptNow();
    check("R8", "level 4 pushed", 64'(curLevel), 64'd4);
    irqReq = 8'h02; globalEn = 1;
    tick();
    check("R5", "k1 code", 64'(excCode), 64'h90);
    clearIn();
    accept = 1; retPulse = 1;
    tick();
    accept = 0; retPulse = 0;
    check("R9", "top replaced", 64'(curLevel), 64'd1);
    returnNow();
    check("R9", "single entry left", 64'(curLevel), 64'd8);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule